// File: doc/BRIEF.md
# Lock-Step Four-Input LUT Network Evaluator

This block evaluates a Boolean network held as a short program of wide steps. Each step carries sixteen slot words, one per lookup unit. In a step, every active slot picks four bits out of a 32-entry one-bit operand space. It looks up the result in a 16-bit truth table carried in the slot word, and writes that result into the one variable register that belongs to the slot. All sixteen slots act together on the same clock edge.

The operand space has three parts. Sixteen variable registers can be written. A fixed band of constant-zero and constant-one entries cannot. The externally preloaded input bits sit at the top of the index range.

A host writes the program slot by slot through a load port and preloads the input bits. It then pulses start with a step count and waits for done. The network outputs are then read from the low variable registers on the readout port. Program words, input bits and start requests are accepted only while the engine is idle.

Top module: `lutstep_engine`

## Requirements
- R1: After reset, busy and done are low and all sixteen variable registers on var_out read 0.
- R2: Operand indices 0–15 read the variable registers. Indices 16–21 read constant 0. Indices 22–26 read constant 1. With N_INPUTS=5, input bit j (in_bits[j]) is read at index 27+j; in general it is read at index 32−N_INPUTS+j.
- R3: A slot word is 42 bits: bit 41 is the nop flag, bits 40:25 the truth table, then four 5-bit source indices s0 (24:20), s1 (19:15), s2 (14:10), s3 (9:5), and the destination index in bits 4:0. The slot result is truth-table bit number {op[s0],op[s1],op[s2],op[s3]}, so s0 is the select MSB and s3 the LSB.
- R4: Slot k writes only variable register k. A slot with the nop flag set, or whose destination index is not k (including any index 16–31), leaves every register unchanged.
- R5: All slots of one step read the operand values as they stood before that step; all writes of a step land on the same edge.
- R6: Accepting start clears all variable registers before the first step executes.
- R7: Steps execute one per clock. done is a one-cycle pulse. With start seen at edge E0 and a step count L≥1, step i commits at edge E(i+1), and done and the final registers are visible after edge EL. A count of 0 executes nothing and pulses done after E1.
- R8: While busy is high, start, program writes (prog_we) and input preloads (in_we) are ignored.
- R9: A program has up to 25 steps (addresses 0–24). A start count above 25 runs exactly 25 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Write one slot word into the program store |
| prog_step | input | 5 | Step address of the slot word (0–24) |
| prog_slot | input | 4 | Slot number within the step |
| prog_word | input | 42 | Slot word, layout per R3 |
| in_we | input | 1 | Load the input bits |
| in_bits | input | N_INPUTS | Input bits, bit j read at operand index 32−N_INPUTS+j |
| start | input | 1 | Begin execution when idle |
| start_len | input | 5 | Number of steps to run |
| busy | output | 1 | High while a program runs |
| done | output | 1 | One-cycle pulse after the last step |
| var_out | output | 16 | Variable registers R0–R15 |

## Verification
Two functions collide in the same edge when one slot overwrites a register that another slot of the same step reads as a source. The bench provokes this with a step where slot 0 copies R1 into R0, slot 1 copies R0 into R1, and slot 2 also reads R0. It judges the swapped values and the copied old value against the pre-step state. A second collision is a host write landing while the engine executes. Slot words, input preloads and a second start are issued mid-run, and the bench checks that the result, a rerun without reloading, and the done cycle all match an undisturbed run.

// File: rtl/lutstep_pkg.sv
// Shared sizes and the slot word type for the LUT network evaluator.
// Assumes a 32-entry one-bit operand space with 16 writable entries.
package lutstep_pkg;
    parameter int NREG      = 32;  // operand space entries
    parameter int NVAR      = 16;  // writable variable registers = slots
    parameter int NSEL      = 4;   // LUT select inputs
    parameter int MAX_STEPS = 25;  // program capacity in steps

    localparam int FN_W      = 1 << NSEL;
    localparam int IDX_W     = $clog2(NREG);
    localparam int SLOT_W    = $clog2(NVAR);
    localparam int STEP_W    = $clog2(MAX_STEPS + 1);
    localparam int ZERO_LAST = 21;  // entries NVAR..ZERO_LAST read 0
    localparam int WORD_W    = 1 + FN_W + NSEL * IDX_W + IDX_W;

    // One slot word; src[NSEL-1] is the first listed source (select MSB).
    typedef struct packed {
        logic                       nop;
        logic [FN_W-1:0]            fn;
        logic [NSEL-1:0][IDX_W-1:0] src;
        logic [IDX_W-1:0]           dst;
    } slot_word_t;
endpackage

// File: rtl/lutstep_prog_mem.sv
// Program store: MAX_STEPS steps of NVAR slot words each.
// Written one slot word at a time; a whole step is read combinationally.
// Assumes the caller gates writes; out-of-range step addresses are dropped
// on write and read back as an all-nop step.
module lutstep_prog_mem
    import lutstep_pkg::*;
(
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [STEP_W-1:0]     wr_step,
    input  logic [SLOT_W-1:0]     wr_slot,
    input  slot_word_t            wr_word,
    input  logic [STEP_W-1:0]     rd_step,
    output slot_word_t            rd_step_words [NVAR]
);
    localparam logic [STEP_W-1:0] LAST_ADDR = STEP_W'(MAX_STEPS - 1);

    slot_word_t mem_q [MAX_STEPS][NVAR];

    // Store one slot word when the address is inside the program capacity.
    always_ff @(posedge clk) begin
        if (wr_en && (wr_step <= LAST_ADDR)) begin
            mem_q[wr_step][wr_slot] <= wr_word;
        end
    end

    // Present every slot word of the addressed step.
    always_comb begin
        for (int k = 0; k < NVAR; k++) begin
            rd_step_words[k] = '{nop: 1'b1, fn: '0, src: '0, dst: '0};
            if (rd_step <= LAST_ADDR) begin
                rd_step_words[k] = mem_q[rd_step][k];
            end
        end
    end
endmodule

// File: rtl/lutstep_operands.sv
// Builds the flat operand vector: variable registers at the bottom,
// a zero band, a one band, and the preloaded input bits at the top.
// Assumes N_INPUTS leaves the zero band intact (N_INPUTS <= NREG-ZERO_LAST-1).
module lutstep_operands
    import lutstep_pkg::*;
#(
    parameter int N_INPUTS = 5
) (
    input  logic [NVAR-1:0]     var_q,
    input  logic [N_INPUTS-1:0] in_q,
    output logic [NREG-1:0]     operands
);
    localparam int IN_BASE = NREG - N_INPUTS;

    for (genvar i = 0; i < NREG; i++) begin : g_op
        if (i < NVAR) begin : g_var
            assign operands[i] = var_q[i];
        end else if (i >= IN_BASE) begin : g_in
            assign operands[i] = in_q[i - IN_BASE];
        end else if (i <= ZERO_LAST) begin : g_zero
            assign operands[i] = 1'b0;
        end else begin : g_one
            assign operands[i] = 1'b1;
        end
    end
endmodule

// File: rtl/lutstep_slot.sv
// One lookup slot: selects four operands, indexes the truth table, and
// requests a write only to its own register when the word is active and
// its destination names this slot.
module lutstep_slot
    import lutstep_pkg::*;
#(
    parameter int SLOT_ID = 0
) (
    input  logic [NREG-1:0] operands,
    input  slot_word_t      word,
    output logic            wr_en,
    output logic            wr_bit
);
    localparam logic [IDX_W-1:0] OWN_IDX = IDX_W'(SLOT_ID);

    logic [NSEL-1:0] sel;

    // Gather the select bits; src[NSEL-1] lands on the MSB.
    always_comb begin
        for (int i = 0; i < NSEL; i++) begin
            sel[i] = operands[word.src[i]];
        end
    end

    // Truth-table lookup and destination gating.
    always_comb begin
        wr_bit = word.fn[sel];
        wr_en  = !word.nop && (word.dst == OWN_IDX);
    end
endmodule

// File: rtl/lutstep_engine.sv
// Top of the LUT network evaluator. Holds the variable registers, the
// input bits and the step sequencer; runs one stored step per clock with
// all slots committing together. Host writes are taken only when idle.
// Synchronous active-low reset.
module lutstep_engine
    import lutstep_pkg::*;
#(
    parameter int N_INPUTS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prog_we,
    input  logic [4:0]          prog_step,
    input  logic [3:0]          prog_slot,
    input  logic [41:0]         prog_word,
    input  logic                in_we,
    input  logic [N_INPUTS-1:0] in_bits,
    input  logic                start,
    input  logic [4:0]          start_len,
    output logic                busy,
    output logic                done,
    output logic [15:0]         var_out
);
    localparam logic [STEP_W-1:0] CAP = STEP_W'(MAX_STEPS);

    logic [NVAR-1:0]     var_q;
    logic [N_INPUTS-1:0] in_q;
    logic [STEP_W-1:0]   pc_q;
    logic [STEP_W-1:0]   len_q;
    logic                busy_q;
    logic                done_q;
    logic [NREG-1:0]     operands;
    slot_word_t          step_words [NVAR];
    logic [NVAR-1:0]     slot_we;
    logic [NVAR-1:0]     slot_bit;
    logic                last_step;

    lutstep_prog_mem u_mem (
        .clk          (clk),
        .wr_en        (prog_we && !busy_q),
        .wr_step      (STEP_W'(prog_step)),
        .wr_slot      (SLOT_W'(prog_slot)),
        .wr_word      (slot_word_t'(prog_word)),
        .rd_step      (pc_q),
        .rd_step_words(step_words)
    );

    lutstep_operands #(.N_INPUTS(N_INPUTS)) u_ops (
        .var_q   (var_q),
        .in_q    (in_q),
        .operands(operands)
    );

    for (genvar k = 0; k < NVAR; k++) begin : g_slot
        lutstep_slot #(.SLOT_ID(k)) u_slot (
            .operands(operands),
            .word    (step_words[k]),
            .wr_en   (slot_we[k]),
            .wr_bit  (slot_bit[k])
        );

        // R4: an idle slot leaves its register alone during a run.
        assert_slot_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_q && !slot_we[k]) |=> $stable(var_q[k]));
    end

    // Final step of the current run (count 0 ends at once).
    always_comb begin
        last_step = (len_q == '0) || (pc_q == len_q - STEP_W'(1));
    end

    // Sequencer, register file updates and host intake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            var_q  <= '0;
            in_q   <= '0;
            pc_q   <= '0;
            len_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (in_we) begin
                    in_q <= in_bits;
                end
                if (start) begin
                    busy_q <= 1'b1;
                    pc_q   <= '0;
                    len_q  <= (STEP_W'(start_len) > CAP) ? CAP : STEP_W'(start_len);
                    var_q  <= '0;
                end
            end else begin
                if (len_q != '0) begin
                    for (int k = 0; k < NVAR; k++) begin
                        if (slot_we[k]) begin
                            var_q[k] <= slot_bit[k];
                        end
                    end
                end
                if (last_step) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    pc_q <= pc_q + STEP_W'(1);
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign var_out = var_q;

    // R6: an accepted start leaves all variable registers at zero.
    assert_clear_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_q) |=> (var_q == '0));

    // R7: done lasts exactly one cycle.
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R7: done marks the end of a run.
    assert_done_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy_q && $past(busy_q)));

    // R8: input bits cannot change while a run is in progress.
    assert_inputs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(in_q));

    // R9: the step pointer stays inside the program capacity.
    assert_pc_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (pc_q < CAP));
endmodule

// File: tb/lutstep_engine_test.sv
`timescale 1ns/1ps
module lutstep_engine_test;
    localparam int NIN = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_we = 1'b0;
    logic [4:0]  prog_step = '0;
    logic [3:0]  prog_slot = '0;
    logic [41:0] prog_word = '0;
    logic        in_we = 1'b0;
    logic [NIN-1:0] in_bits = '0;
    logic        start = 1'b0;
    logic [4:0]  start_len = '0;
    logic        busy, done;
    logic [15:0] var_out;

    int total = 0;
    int bad = 0;

    lutstep_engine #(.N_INPUTS(NIN)) uut (
        .clk(clk), .rst_n(rst_n),
        .prog_we(prog_we), .prog_step(prog_step), .prog_slot(prog_slot),
        .prog_word(prog_word),
        .in_we(in_we), .in_bits(in_bits),
        .start(start), .start_len(start_len),
        .busy(busy), .done(done), .var_out(var_out)
    );

    always #2.5 clk = ~clk;

    // Table: truth table, s0..s3, input bits, expected R0 (fields per R2/R3).
    localparam int NVEC = 10;
    localparam logic [41:0] VEC [NVEC] = '{
        {16'hF6E0, 5'd27, 5'd28, 5'd29, 5'd30, 5'b01011, 1'b1},
        {16'hF6E0, 5'd16, 5'd16, 5'd16, 5'd16, 5'b11111, 1'b0},
        {16'hF6E0, 5'd22, 5'd22, 5'd22, 5'd22, 5'b00000, 1'b1},
        {16'h0002, 5'd16, 5'd16, 5'd16, 5'd22, 5'b00000, 1'b1},
        {16'h0100, 5'd22, 5'd16, 5'd16, 5'd16, 5'b00000, 1'b1},
        {16'h0100, 5'd16, 5'd16, 5'd16, 5'd22, 5'b00000, 1'b0},
        {16'h8000, 5'd27, 5'd28, 5'd29, 5'd30, 5'b01111, 1'b1},
        {16'h8000, 5'd31, 5'd31, 5'd31, 5'd31, 5'b10000, 1'b1},
        {16'h0400, 5'd26, 5'd21, 5'd26, 5'd21, 5'b00000, 1'b1},
        {16'hFFFE, 5'd21, 5'd16, 5'd20, 5'd17, 5'b11111, 1'b0}
    };

    function automatic logic [41:0] mk(input logic nop, input logic [15:0] fn,
                                       input logic [4:0] s0, input logic [4:0] s1,
                                       input logic [4:0] s2, input logic [4:0] s3,
                                       input logic [4:0] dst);
        return {nop, fn, s0, s1, s2, s3, dst};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input int step, input int slot, input logic [41:0] w);
        prog_we = 1'b1; prog_step = 5'(step); prog_slot = 4'(slot); prog_word = w;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic clear_step(input int step);
        for (int k = 0; k < 16; k++) put(step, k, mk(1'b1, 16'h0, 0, 0, 0, 0, 5'(k)));
    endtask

    task automatic preload(input logic [NIN-1:0] v);
        in_we = 1'b1; in_bits = v;
        @(negedge clk);
        in_we = 1'b0;
    endtask

    // Pulse start; n is the negedge index at which done is first seen.
    task automatic run(input int len, output int n);
        start = 1'b1; start_len = 5'(len);
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_up;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_up();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 var_out", 32'(var_out), 0);
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);

        // Table walk (R2, R3): single-step program, result in R0.
        clear_step(0);
        for (int v = 0; v < NVEC; v++) begin
            put(0, 0, mk(1'b0, VEC[v][41:26], VEC[v][25:21], VEC[v][20:16],
                         VEC[v][15:11], VEC[v][10:6], 5'd0));
            preload(VEC[v][5:1]);
            run(1, n);
            check($sformatf("R3 R2 vector %0d", v), 32'(var_out), 32'(VEC[v][0]));
            check("R7 one-step done cycle", n, 2);
        end

        // R5: swap inside one step; slot 2 also reads old R0.
        clear_step(0); clear_step(1);
        put(0, 0, mk(1'b0, 16'hFFFF, 16, 16, 16, 16, 0));
        put(1, 0, mk(1'b0, 16'hAAAA, 16, 16, 16, 1, 0));
        put(1, 1, mk(1'b0, 16'hAAAA, 16, 16, 16, 0, 1));
        put(1, 2, mk(1'b0, 16'hAAAA, 16, 16, 16, 0, 2));
        run(2, n);
        check("R5 swap and old-value read", 32'(var_out), 32'h0006);
        check("R7 two-step done cycle", n, 3);
        @(negedge clk);
        check("R7 done one cycle", 32'(done), 0);

        // R4: own-register writes, mismatched destination, nop hold.
        clear_step(0); clear_step(1);
        put(0, 6, mk(1'b0, 16'hFFFF, 16, 16, 16, 16, 6));
        put(1, 6, mk(1'b1, 16'h0000, 16, 16, 16, 16, 6));
        put(1, 3, mk(1'b0, 16'hFFFF, 16, 16, 16, 16, 4));
        put(1, 5, mk(1'b0, 16'hFFFF, 16, 16, 16, 16, 20));
        put(1, 7, mk(1'b0, 16'hFFFF, 16, 16, 16, 16, 7));
        run(2, n);
        check("R4 slot gating", 32'(var_out), 32'h00C0);

        // R6: a run of an all-nop step shows the cleared registers.
        clear_step(0);
        run(1, n);
        check("R6 clear at start", 32'(var_out), 0);

        // R7: zero-length run.
        put(0, 9, mk(1'b0, 16'hFFFF, 16, 16, 16, 16, 9));
        run(0, n);
        check("R7 zero-length done cycle", n, 2);
        check("R7 zero-length no execution", 32'(var_out), 0);

        // R8: host activity while busy is ignored.
        clear_step(0); clear_step(1); clear_step(2);
        put(0, 0, mk(1'b0, 16'hAAAA, 16, 16, 16, 27, 0));
        put(1, 1, mk(1'b0, 16'hAAAA, 16, 16, 16, 0, 1));
        put(2, 2, mk(1'b0, 16'hAAAA, 16, 16, 16, 1, 2));
        preload(5'b00001);
        start = 1'b1; start_len = 5'd3;
        @(negedge clk);
        start = 1'b0;
        // n=1: disturb while busy
        prog_we = 1'b1; prog_step = 5'd2; prog_slot = 4'd2;
        prog_word = mk(1'b1, 16'h0, 0, 0, 0, 0, 2);
        in_we = 1'b1; in_bits = 5'b00000;
        @(negedge clk);
        prog_we = 1'b0; in_we = 1'b0;
        // n=2: a second start
        start = 1'b1; start_len = 5'd1;
        @(negedge clk);
        start = 1'b0;
        n = 3;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        check("R8 start ignored, done cycle", n, 4);
        check("R8 run result", 32'(var_out), 32'h0007);
        run(3, n);
        check("R8 program and inputs kept", 32'(var_out), 32'h0007);

        // R9: full 25-step program, then an oversize count.
        for (int s = 0; s < 25; s++) begin
            clear_step(s);
            put(s, 0, mk(1'b0, 16'h5555, 16, 16, 16, 0, 0));
        end
        put(24, 1, mk(1'b0, 16'hFFFF, 16, 16, 16, 16, 1));
        run(25, n);
        check("R9 full program result", 32'(var_out), 32'h0003);
        check("R9 full program done cycle", n, 26);
        run(31, n);
        check("R9 clamped count result", 32'(var_out), 32'h0003);
        check("R9 clamped count done cycle", n, 26);

        // R1: synchronous reset clears state.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset clears registers", 32'(var_out), 0);
        check("R1 reset busy low", 32'(busy), 0);

        finish_up();
    end
endmodule